// File: doc/BRIEF.md
# Walking-One Harness Continuity Scanner

This block checks a cable harness by energising its wires one at a time and reading back every far-end wire. Each drive line has an enable: when an enable is high the pad drives the wire high, and when it is low the pad is high-impedance. An external pull reads a released wire as 0, so two shorted wires never fight each other. The active line starts at wire 0 and moves up by one wire per step, the way a serial-in parallel-out chain shifts a single 1.

For each step the scanner first waits a programmable number of serial periods so that a slow harness edge can finish changing. It then loads the receive pins into a parallel-in serial-out chain and shifts that chain out one bit per serial tick. It rebuilds the received pattern and compares it with the expected pattern for that step. The expected patterns sit in a register array that the host writes, one entry per drive wire. A junction gives several set bits and passes when the expected entry lists the same bits. A short gives extra set bits and an open gives missing bits, and both are mismatches. The serial tick comes from a clock-enable divider: a divisor of 800 gives 62.5 kHz from a 50 MHz clock. Adding drive and receive stages is done by raising the chain length parameter.

Top module: `harness_scanner`

## Requirements
- R1: After a synchronous active-high reset, drive_en is all zero and done, error and busy are 0.
- R2: At most one bit of drive_en is set at any time, and all bits are 0 while busy is 0. During step k of a scan, only bit k is set: step 0 enables bit 0 and each advance moves the enable up one bit.
- R3: With S the value of settle_periods sampled when a step begins, a step lasts exactly (S+N+2)*DIV+1 clocks. The receive pins are sampled on the (S+2)*DIV-th rising edge after the step begins.
- R4: Bit i of the captured pattern equals bit i of rx_in as sampled, so the serial readout keeps the wire order.
- R5: A step whose captured pattern differs from its expected entry ends the scan on the next edge. This covers both extra set bits (short) and missing set bits (open). That edge sets done=1 and error=1, puts the step index on fail_step and the captured pattern on fail_pattern, and releases all drive lines.
- R6: A step whose captured pattern has several set bits (a junction) passes when it equals its expected entry.
- R7: When all N steps match, done=1 and error=0, and drive_en returns to zero.
- R8: done, error, fail_step and fail_pattern hold while idle until the next start. A start while idle clears done and error and begins step 0 on the next edge. A start while busy is ignored.
- R9: A clock edge with exp_wr_en=1 writes exp_wr_data to expected entry exp_wr_addr. Entry k is the pattern expected when wire k is driven, with bit j meaning far-end wire j reads 1.
- R10: The serial tick fires once every DIV clocks, counted from the start of each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (used only while idle) |
| settle_periods | input | SETTLE_W | Extra serial periods to wait before sampling, per step |
| exp_wr_en | input | 1 | Write strobe for the expected-pattern array |
| exp_wr_addr | input | SW | Entry (drive wire index) to write |
| exp_wr_data | input | N | Expected far-end pattern for that wire |
| rx_in | input | N | Far-end receive pins (released wires read 0) |
| drive_en | output | N | Per-wire drive enable: 1 drives high, 0 is high-impedance |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | The last scan has finished |
| error | output | 1 | The last scan stopped on a mismatch |
| fail_step | output | SW | Step index of the mismatch |
| fail_pattern | output | N | Captured pattern of the mismatch |

## Verification
The bench builds the scanner with N=8, DIV=4 and SETTLE_W=4, so one full scan takes a few hundred clocks. Every step boundary, sample edge and tick can therefore be compared against a behavioural model on every clock. The harness model in the bench maps each driven wire to a set of far-end wires and can delay its response by several clocks. This makes shorts, opens and junctions reachable, as well as a settling time too short for a slow harness. The asymmetric short pattern shows whether the readout keeps the wire order.

// File: rtl/harness_scan_pkg.sv
package harness_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LOAD,
        ST_SHIFT,
        ST_CHECK
    } scan_state_e;

endpackage

// File: rtl/hs_tick_gen.sv
// Clock-enable divider: one tick every DIV clocks, restarted by clear.
module hs_tick_gen #(
    parameter int unsigned DIV = 800,
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = !clear && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q + CW'(1);
        if (clear || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hs_drive_chain.sv
// Serial-in parallel-out chain holding the walking enable.
module hs_drive_chain #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift,
    input  logic         sin,
    output logic [N-1:0] q
);

    logic [N-1:0] q_d, q_q;
    logic [N:0]   grown;

    always_comb begin
        grown = {q_q, sin};
        q_d   = q_q;
        if (clear) begin
            q_d = '0;
        end else if (shift) begin
            q_d = grown[N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

endmodule

// File: rtl/hs_rx_chain.sv
// Parallel-in serial-out chain: load the receive pins, shift out MSB first.
module hs_rx_chain #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [N-1:0] par_in,
    output logic         sout
);

    logic [N-1:0] q_d, q_q;
    logic [N:0]   grown;

    always_comb begin
        grown = {q_q, 1'b0};
        q_d   = q_q;
        if (load) begin
            q_d = par_in;
        end else if (shift) begin
            q_d = grown[N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign sout = q_q[N-1];

endmodule

// File: rtl/hs_expect_store.sv
// One expected far-end pattern per drive wire.
module hs_expect_store #(
    parameter int unsigned N = 8,
    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [N-1:0]  wr_data,
    input  logic [SW-1:0] rd_idx,
    output logic [N-1:0]  rd_data
);

    logic [N-1:0] row_q [N];

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [N-1:0] row_d;

        always_comb begin
            row_d = row_q[r];
            if (wr_en && (wr_addr == SW'(r))) begin
                row_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q[r] <= '0;
            end else begin
                row_q[r] <= row_d;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < N; r++) begin
            if (rd_idx == SW'(r)) begin
                rd_data = row_q[r];
            end
        end
    end

endmodule

// File: rtl/harness_scanner.sv
module harness_scanner
    import harness_scan_pkg::*;
#(
    parameter int unsigned N        = 8,
    parameter int unsigned DIV      = 800,
    parameter int unsigned SETTLE_W = 8,
    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_periods,
    input  logic                exp_wr_en,
    input  logic [SW-1:0]       exp_wr_addr,
    input  logic [N-1:0]        exp_wr_data,
    input  logic [N-1:0]        rx_in,
    output logic [N-1:0]        drive_en,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [SW-1:0]       fail_step,
    output logic [N-1:0]        fail_pattern
);

    localparam logic [SW-1:0] LAST_IDX = SW'(N - 1);

    typedef struct packed {
        scan_state_e         state;
        logic [SW-1:0]       step;
        logic [SETTLE_W-1:0] settle;
        logic [SW-1:0]       bits;
        logic [N-1:0]        cap;
        logic                done;
        logic                error;
        logic [SW-1:0]       fail_step;
        logic [N-1:0]        fail_pat;
    } ctrl_t;

    ctrl_t        c_d, c_q;
    logic         tick;
    logic         div_clear;
    logic         drv_clear, drv_shift, drv_sin;
    logic         rx_load, rx_shift, rx_sout;
    logic [N-1:0] exp_row;
    logic [N:0]   cap_grown;

    hs_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (div_clear),
        .tick  (tick)
    );

    hs_drive_chain #(.N(N)) u_drive (
        .clk   (clk),
        .rst   (rst),
        .clear (drv_clear),
        .shift (drv_shift),
        .sin   (drv_sin),
        .q     (drive_en)
    );

    hs_rx_chain #(.N(N)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .load   (rx_load),
        .shift  (rx_shift),
        .par_in (rx_in),
        .sout   (rx_sout)
    );

    hs_expect_store #(.N(N)) u_expect (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (exp_wr_en),
        .wr_addr (exp_wr_addr),
        .wr_data (exp_wr_data),
        .rd_idx  (c_q.step),
        .rd_data (exp_row)
    );

    always_comb begin
        c_d       = c_q;
        div_clear = (c_q.state == ST_IDLE) || (c_q.state == ST_CHECK);
        drv_clear = 1'b0;
        drv_shift = 1'b0;
        drv_sin   = 1'b0;
        rx_load   = 1'b0;
        rx_shift  = 1'b0;
        cap_grown = {c_q.cap, rx_sout};

        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.state     = ST_SETTLE;
                    c_d.step      = '0;
                    c_d.settle    = settle_periods;
                    c_d.done      = 1'b0;
                    c_d.error     = 1'b0;
                    c_d.fail_step = '0;
                    c_d.fail_pat  = '0;
                    drv_shift     = 1'b1;
                    drv_sin       = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tick) begin
                    if (c_q.settle == '0) begin
                        c_d.state = ST_LOAD;
                    end else begin
                        c_d.settle = c_q.settle - SETTLE_W'(1);
                    end
                end
            end
            ST_LOAD: begin
                if (tick) begin
                    rx_load   = 1'b1;
                    c_d.bits  = '0;
                    c_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    rx_shift = 1'b1;
                    c_d.cap  = cap_grown[N-1:0];
                    if (c_q.bits == LAST_IDX) begin
                        c_d.state = ST_CHECK;
                    end else begin
                        c_d.bits = c_q.bits + SW'(1);
                    end
                end
            end
            ST_CHECK: begin
                if (c_q.cap != exp_row) begin
                    c_d.state     = ST_IDLE;
                    c_d.done      = 1'b1;
                    c_d.error     = 1'b1;
                    c_d.fail_step = c_q.step;
                    c_d.fail_pat  = c_q.cap;
                    drv_clear     = 1'b1;
                end else if (c_q.step == LAST_IDX) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                    drv_clear = 1'b1;
                end else begin
                    c_d.state  = ST_SETTLE;
                    c_d.step   = c_q.step + SW'(1);
                    c_d.settle = settle_periods;
                    drv_shift  = 1'b1;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
                drv_clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '{state: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy         = (c_q.state != ST_IDLE);
    assign done         = c_q.done;
    assign error        = c_q.error;
    assign fail_step    = c_q.fail_step;
    assign fail_pattern = c_q.fail_pat;

endmodule

// File: rtl/harness_scanner_checks.sv
module harness_scanner_checks #(
    parameter int unsigned N  = 8,
    parameter int unsigned SW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [N-1:0]  drive_en,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [SW-1:0] fail_step,
    input logic [N-1:0]  fail_pattern
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (drive_en == '0 && !done && !error && !busy));

    p_single_line_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_en));

    p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (drive_en == '0));

    p_walk_up_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && drive_en != '0 && drive_en != $past(drive_en))
        |-> (drive_en == ($past(drive_en) << 1)));

    p_error_has_done_r5: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    p_mismatch_stops_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> (!busy && drive_en == '0));

    p_result_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(done) && $stable(error)
                               && $stable(fail_step) && $stable(fail_pattern)));

    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done && !error));

endmodule

bind harness_scanner harness_scanner_checks #(.N(N), .SW(SW)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .drive_en     (drive_en),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .fail_step    (fail_step),
    .fail_pattern (fail_pattern)
);

// File: tb/test_harness_scanner.sv
module test_harness_scanner;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DIV = 4;
    localparam int SETW = 4;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [SETW-1:0] settle = 4'd1;
    logic            wr_en = 1'b0;
    logic [SW-1:0]   wr_addr = '0;
    logic [N-1:0]    wr_data = '0;
    logic [N-1:0]    rx_in = '0;
    logic [N-1:0]    drive_en;
    logic            busy, done, error;
    logic [SW-1:0]   fail_step;
    logic [N-1:0]    fail_pattern;

    harness_scanner #(.N(N), .DIV(DIV), .SETTLE_W(SETW)) i_harness_scanner (
        .clk(clk), .rst(rst), .start(start), .settle_periods(settle),
        .exp_wr_en(wr_en), .exp_wr_addr(wr_addr), .exp_wr_data(wr_data),
        .rx_in(rx_in), .drive_en(drive_en), .busy(busy), .done(done),
        .error(error), .fail_step(fail_step), .fail_pattern(fail_pattern)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Harness model: wire i, when driven, reaches far ends conn[i].
    logic [N-1:0] conn [N];
    logic [N-1:0] exp_m [N];
    logic [N-1:0] hist [32];
    int           delay_cy = 0;

    // Behavioural reference of the scan.
    bit           m_run = 0, m_done = 0, m_err = 0;
    logic [N-1:0] m_drv = '0, m_cap = '0, m_fpat = '0;
    int           m_step = 0, m_k = 0, m_s = 0, m_fstep = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_done = 0; m_err = 0; m_drv = '0;
            m_fstep = 0; m_fpat = '0;
        end else if (!m_run) begin
            if (start) begin
                m_run = 1; m_step = 0; m_k = 0; m_done = 0; m_err = 0;
                m_drv = 1; m_fstep = 0; m_fpat = '0; m_s = int'(settle);
            end
        end else begin
            if (m_k == (m_s + 2) * DIV - 1) m_cap = rx_in;
            if (m_k == (m_s + N + 2) * DIV) begin
                if (m_cap != exp_m[m_step]) begin
                    m_run = 0; m_done = 1; m_err = 1; m_drv = '0;
                    m_fstep = m_step; m_fpat = m_cap;
                end else if (m_step == N - 1) begin
                    m_run = 0; m_done = 1; m_drv = '0;
                end else begin
                    m_step++; m_k = 0; m_drv = N'(1) << m_step;
                    m_s = int'(settle);
                end
            end else begin
                m_k++;
            end
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] seen;
        chk(drive_en == m_drv, "R2 R3 R10 drive_en per cycle", 32'(drive_en), 32'(m_drv));
        chk(done == m_done, "R7 R8 done per cycle", 32'(done), 32'(m_done));
        chk(error == m_err, "R5 error per cycle", 32'(error), 32'(m_err));
        chk(busy == m_run, "R8 busy per cycle", 32'(busy), 32'(m_run));
        for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = drive_en;
        seen = '0;
        for (int i = 0; i < N; i++) if (hist[delay_cy][i]) seen |= conn[i];
        rx_in = seen;
    end

    task automatic write_exp(input int a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = SW'(a); wr_data = d; exp_m[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic straight();
        for (int i = 0; i < N; i++) begin
            conn[i] = N'(1) << i;
            write_exp(i, N'(1) << i);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_scan();
        int t;
        pulse_start();
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R7 scan completes", t, 20000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) hist[i] = '0;
        for (int i = 0; i < N; i++) begin conn[i] = '0; exp_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(drive_en == '0, "R1 reset drive_en", 32'(drive_en), 0);
        chk(!done && !error && !busy, "R1 reset flags", {done, error, busy}, 0);

        // Clean one-to-one harness, with a start pulse mid-scan (ignored).
        straight();
        settle = 4'd1;
        pulse_start();
        repeat (100) @(negedge clk);
        chk(drive_en == 8'h04, "R2 step 2 drives bit 2", 32'(drive_en), 32'h04);
        pulse_start();
        while (!done) @(negedge clk);
        chk(!error, "R7 clean harness passes", 32'(error), 0);
        chk(drive_en == '0, "R2 released when idle", 32'(drive_en), 0);

        // Short between wires 2 and 3.
        conn[2] = 8'h0C; conn[3] = 8'h0C;
        run_scan();
        chk(error, "R5 short flagged", 32'(error), 1);
        chk(fail_step == 3'd2, "R5 short step", 32'(fail_step), 2);
        chk(fail_pattern == 8'h0C, "R4 R5 short pattern order", 32'(fail_pattern), 32'h0C);
        repeat (20) @(negedge clk);
        chk(done && error && fail_step == 3'd2, "R8 result held", {done, error, fail_step}, 32'h1A);

        // Junction: wires 1, 5 and 6 joined, expected entries match.
        straight();
        conn[1] = 8'h62; conn[5] = 8'h62; conn[6] = 8'h62;
        write_exp(1, 8'h62); write_exp(5, 8'h62); write_exp(6, 8'h62);
        run_scan();
        chk(done && !error, "R6 junction accepted", {done, error}, 2);

        // Open wire 4.
        straight();
        conn[4] = '0;
        run_scan();
        chk(error && fail_step == 3'd4, "R5 open step", {error, fail_step}, 32'hC);
        chk(fail_pattern == '0, "R5 open pattern", 32'(fail_pattern), 0);

        // Slow harness: too little settle, then enough.
        straight();
        delay_cy = 12;
        settle = 4'd0;
        run_scan();
        chk(error && fail_step == 3'd0, "R3 short settle fails", {error, fail_step}, 32'h8);
        chk(fail_pattern == '0, "R3 stale pattern", 32'(fail_pattern), 0);
        settle = 4'd3;
        run_scan();
        chk(done && !error, "R3 long settle passes", {done, error}, 2);
        delay_cy = 0;

        // Wrong expected entry written for step 6.
        settle = 4'd1;
        write_exp(6, 8'h00);
        run_scan();
        chk(error && fail_step == 3'd6, "R9 expected entry used", {error, fail_step}, 32'hE);
        chk(fail_pattern == 8'h40, "R9 R4 captured pattern", 32'(fail_pattern), 32'h40);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule